// File: doc/BRIEF.md
# Split-Aware Bus Arbiter

This block is the request-masking and grant stage of a shared-bus arbiter. Each master raises a request line. When a slave answers a transfer with a SPLIT response, the block sets a mask bit for the master that owned that transfer. That master's request is then hidden from grant selection until a slave pulses the matching bit of the split-release bus. The release bus is the bitwise OR of the release outputs of every slave that can split, and the block samples it on every clock.

Grant selection uses fixed priority: master 0 ranks highest. When no unmasked master is requesting, a parameterised default master receives the grant. This covers the case where every other master has been split. The grant changes only on cycles where the bus ready signal is high.

The block drives a 4-bit master tag that names the granted master during the address phase. It also keeps the tag of the master in the data phase, so that a later SPLIT response is charged to the correct master.

Top module: `split_aware_arbiter`

## Requirements
- R1: After reset, the grant is one-hot on the default master (`DEF_MST`), the tag equals `DEF_MST`, and no mask bit is set, so `masked_req_o` equals `req_i`.
- R2: A cycle with `resp_i` = 2'b11 (SPLIT) sets the mask bit of the data-phase owner. From the next cycle that master's bit in `masked_req_o` is 0 and it cannot win a grant.
- R3: A release bit that is high for a single cycle clears the matching mask bit from the next cycle.
- R4: If a SPLIT response and a release bit for the same master fall in the same cycle, the release wins and the mask bit ends up clear.
- R5: Release bits at positions `N_MST` and above have no effect on any mask bit.
- R6: On a ready-high cycle, the next grant goes to the lowest-indexed master in `masked_req_o`. A released master with a lower-index master still requesting is not granted.
- R7: On a ready-high cycle with no masked request, the next grant goes to the default master, including when every other master is masked.
- R8: While `ready_i` is low, the grant and the tag keep their values.
- R9: The tag is the binary index of the granted master. The data-phase owner is the tag that was present on the most recent ready-high cycle.
- R10: Response codes 2'b00 (OKAY), 2'b01 (ERROR) and 2'b10 (RETRY) leave the mask unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_MST | Raw request line of each master |
| ready_i | input | 1 | Bus ready; high ends the current transfer phase |
| resp_i | input | 2 | Slave response code (00 OKAY, 01 ERROR, 10 RETRY, 11 SPLIT) |
| split_rel_i | input | 16 | OR-combined split-release bus, one bit per master number |
| masked_req_o | output | N_MST | Requests after split masking |
| grant_o | output | N_MST | One-hot grant |
| mst_tag_o | output | 4 | Index of the granted master (address-phase tag) |

## Verification
The bench goes after the following corner cases:
- **Set and release in the same cycle for one master.** A design that gives the set priority would leave that master stranded with no further release coming.
- **Release bits above the master count.** A design that lets them alias onto real masters would free the wrong master.
- **Every non-default master split.** Here the grant must park on the default master; a wrong design would leave the grant on a masked master or produce no grant at all.
- **Charging the split to the right master.** The bench changes the grant between address phase and data phase. A design that charged the split to the address-phase master instead of the data-phase owner would mask the wrong bit.
- **Ready-low cycles.** The bench checks that grant and tag do not move while ready is low.

// File: rtl/sam_pkg.sv
package sam_pkg;
    localparam int unsigned TAG_W   = 4;
    localparam int unsigned MAX_MST = 16;

    typedef enum logic [1:0] {
        RSP_OKAY  = 2'b00,
        RSP_ERROR = 2'b01,
        RSP_RETRY = 2'b10,
        RSP_SPLIT = 2'b11
    } rsp_e;
endpackage

// File: rtl/sam_mask_track.sv
module sam_mask_track
    import sam_pkg::*;
#(
    parameter int unsigned N_MST = 6
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               split_i,
    input  logic [TAG_W-1:0]   owner_i,
    input  logic [MAX_MST-1:0] rel_i,
    output logic [N_MST-1:0]   mask_o
);
    typedef struct packed {
        logic [N_MST-1:0] mask;
    } mt_state_t;

    mt_state_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        for (int i = 0; i < N_MST; i++) begin
            if (split_i && (owner_i == TAG_W'(i))) begin
                st_d.mask[i] = 1'b1;
            end
            if (rel_i[i]) begin
                st_d.mask[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign mask_o = st_q.mask;

    logic [MAX_MST-1:0] mask_x;
    assign mask_x = MAX_MST'(st_q.mask);

    p_split_sets_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (split_i && ({1'b0, owner_i} < 5'(N_MST)) && !rel_i[owner_i])
        |=> mask_x[$past(owner_i)]);

    p_quiet_resp_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !split_i |=> ((st_q.mask & ~$past(st_q.mask)) == '0));

    for (genvar g = 0; g < N_MST; g++) begin : g_rel_chk
        p_release_clears_r3: assert property (@(posedge clk) disable iff (!rst_n)
            rel_i[g] |=> !st_q.mask[g]);
    end
endmodule

// File: rtl/sam_prio_sel.sv
module sam_prio_sel
    import sam_pkg::*;
#(
    parameter int unsigned N_MST   = 6,
    parameter int unsigned DEF_MST = 5
) (
    input  logic [N_MST-1:0] req_i,
    output logic [N_MST-1:0] grant_o
);
    always_comb begin
        grant_o = '0;
        for (int i = N_MST - 1; i >= 0; i--) begin
            if (req_i[i]) begin
                grant_o    = '0;
                grant_o[i] = 1'b1;
            end
        end
        if (req_i == '0) begin
            grant_o[DEF_MST] = 1'b1;
        end
    end
endmodule

// File: rtl/split_aware_arbiter.sv
module split_aware_arbiter
    import sam_pkg::*;
#(
    parameter int unsigned N_MST   = 6,
    parameter int unsigned DEF_MST = N_MST - 1
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [N_MST-1:0]   req_i,
    input  logic               ready_i,
    input  logic [1:0]         resp_i,
    input  logic [MAX_MST-1:0] split_rel_i,
    output logic [N_MST-1:0]   masked_req_o,
    output logic [N_MST-1:0]   grant_o,
    output logic [TAG_W-1:0]   mst_tag_o
);
    localparam logic [N_MST-1:0] DEF_ONEHOT = N_MST'(1) << DEF_MST;

    typedef struct packed {
        logic [N_MST-1:0] grant;
        logic [TAG_W-1:0] dtag;
    } arb_state_t;

    arb_state_t       st_d, st_q;
    logic [N_MST-1:0] mask;
    logic [N_MST-1:0] sel_grant;
    logic [TAG_W-1:0] tag;
    logic             split_seen;

    assign split_seen = (rsp_e'(resp_i) == RSP_SPLIT);

    sam_mask_track #(.N_MST(N_MST)) i_mask (
        .clk     (clk),
        .rst_n   (rst_n),
        .split_i (split_seen),
        .owner_i (st_q.dtag),
        .rel_i   (split_rel_i),
        .mask_o  (mask)
    );

    assign masked_req_o = req_i & ~mask;

    sam_prio_sel #(.N_MST(N_MST), .DEF_MST(DEF_MST)) i_sel (
        .req_i   (masked_req_o),
        .grant_o (sel_grant)
    );

    always_comb begin
        tag = '0;
        for (int i = 0; i < N_MST; i++) begin
            if (st_q.grant[i]) begin
                tag = TAG_W'(i);
            end
        end
    end

    always_comb begin
        st_d = st_q;
        if (ready_i) begin
            st_d.grant = sel_grant;
            st_d.dtag  = tag;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.grant <= DEF_ONEHOT;
            st_q.dtag  <= TAG_W'(DEF_MST);
        end else begin
            st_q <= st_d;
        end
    end

    assign grant_o   = st_q.grant;
    assign mst_tag_o = tag;

    p_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !ready_i |=> ($stable(grant_o) && $stable(mst_tag_o)));

    p_onehot_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(grant_o) == 1);

    p_default_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && (masked_req_o == '0)) |=> (grant_o == DEF_ONEHOT));

    p_masked_loses_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (ready_i && (masked_req_o != '0)) |=> ((grant_o & $past(masked_req_o)) != '0));
endmodule

// File: tb/test_split_aware_arbiter.sv
module test_split_aware_arbiter;
    localparam int N   = 6;
    localparam int DEF = 5;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [N-1:0] req = '0;
    logic         rdy = 1'b0;
    logic [1:0]   resp = 2'b00;
    logic [15:0]  rel = '0;
    logic [N-1:0] masked;
    logic [N-1:0] grant;
    logic [3:0]   tag;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    logic [N-1:0] m_mask;
    logic [N-1:0] m_grant;
    logic [3:0]   m_dph;

    always #10 clk = ~clk;

    split_aware_arbiter #(.N_MST(N), .DEF_MST(DEF)) i_split_aware_arbiter (
        .clk(clk), .rst_n(rst_n), .req_i(req), .ready_i(rdy), .resp_i(resp),
        .split_rel_i(rel), .masked_req_o(masked), .grant_o(grant), .mst_tag_o(tag)
    );

    function automatic logic [N-1:0] f_sel(input logic [N-1:0] r);
        for (int i = 0; i < N; i++) if (r[i]) return N'(1) << i;
        return N'(1) << DEF;
    endfunction

    function automatic logic [3:0] f_idx(input logic [N-1:0] g);
        for (int i = 0; i < N; i++) if (g[i]) return 4'(i);
        return 4'd0;
    endfunction

    task automatic chk(input string rq, input string what, input logic [15:0] act, input logic [15:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    task automatic check_all(input string rq_g, input string rq_m);
        chk(rq_g, "grant", 16'(grant), 16'(m_grant));
        chk("R9", "tag", 16'(tag), 16'(f_idx(m_grant)));
        chk(rq_m, "masked", 16'(masked), 16'(req & ~m_mask));
    endtask

    task automatic cyc(input logic [N-1:0] r, input logic y, input logic [1:0] rs,
                       input logic [15:0] rl, input string rq_g, input string rq_m);
        logic [N-1:0] nm;
        @(negedge clk);
        req = r; rdy = y; resp = rs; rel = rl;
        @(posedge clk);
        nm = m_mask;
        for (int i = 0; i < N; i++) begin
            if (rs == 2'b11 && m_dph == 4'(i)) nm[i] = 1'b1;
            if (rl[i]) nm[i] = 1'b0;
        end
        if (y) begin
            m_dph   = f_idx(m_grant);
            m_grant = f_sel(r & ~m_mask);
        end
        m_mask = nm;
        #2;
        check_all(rq_g, rq_m);
    endtask

    task automatic split_master(input int k, input string rq);
        cyc(N'(1) << k, 1'b1, 2'b00, 16'h0, "R6", "R2");
        cyc(N'(1) << k, 1'b1, 2'b00, 16'h0, "R9", "R2");
        cyc('0, 1'b0, 2'b11, 16'h0, "R8", rq);
        cyc('1, 1'b0, 2'b11, 16'h0, "R8", rq);
    endtask

    initial begin
        m_mask = '0; m_grant = N'(1) << DEF; m_dph = 4'(DEF);
        req = '1;
        #35;
        check_all("R1", "R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_all("R1", "R1");

        cyc(6'b001100, 1'b1, 2'b00, 16'h0, "R6", "R1");
        cyc(6'b000110, 1'b1, 2'b00, 16'h0, "R6", "R1");
        cyc(6'b111111, 1'b0, 2'b00, 16'h0, "R8", "R1");
        cyc(6'b010000, 1'b0, 2'b00, 16'h0, "R8", "R1");

        split_master(1, "R2");
        cyc('1, 1'b1, 2'b00, 16'h0, "R6", "R2");
        cyc('1, 1'b1, 2'b01, 16'h0, "R6", "R10");
        cyc('1, 1'b1, 2'b10, 16'h0, "R6", "R10");
        cyc('1, 1'b0, 2'b00, 16'hFFC0, "R8", "R5");
        cyc('1, 1'b0, 2'b00, 16'h0, "R8", "R5");
        cyc('1, 1'b0, 2'b00, 16'h0002, "R8", "R3");
        cyc('1, 1'b1, 2'b00, 16'h0, "R6", "R3");

        cyc(6'b000001, 1'b1, 2'b00, 16'h0, "R6", "R4");
        cyc(6'b000001, 1'b1, 2'b00, 16'h0, "R9", "R4");
        cyc('1, 1'b0, 2'b11, 16'h0001, "R8", "R4");
        cyc('1, 1'b0, 2'b00, 16'h0, "R8", "R4");

        for (int k = 0; k < DEF; k++) split_master(k, "R2");
        cyc('1, 1'b1, 2'b00, 16'h0, "R7", "R2");
        cyc(6'b011111, 1'b1, 2'b00, 16'h0, "R7", "R2");
        cyc(6'b011111, 1'b1, 2'b00, 16'h0008, "R7", "R3");
        cyc(6'b011111, 1'b1, 2'b00, 16'h0, "R6", "R3");
        cyc(6'b011111, 1'b1, 2'b00, 16'h0004, "R6", "R3");

        void'($urandom(32'd1234));
        for (int t = 0; t < 3000; t++) begin
            logic [15:0] rl;
            logic [1:0]  rs;
            rl = (($urandom % 4) == 0) ? 16'(1 << ($urandom % 16)) : 16'h0;
            rs = (($urandom % 6) == 0) ? 2'b11 : 2'($urandom % 3);
            cyc(N'($urandom), (($urandom % 4) != 0), rs, rl, "R6", "R2");
        end

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end
endmodule